// File: doc/BRIEF.md
# Bounce-Back LED Chase Sequencer

This block lights a contiguous group of LEDs in a row and sweeps that group from one end of the row to the other. The group turns back automatically at each end. The group moves by exactly one position per step, and a step happens only when an external rate divider raises a one-cycle tick. Because the rate divider sets the sweep speed, the speed can change without any change to this block.

A separate debouncer supplies a clean one-cycle pulse that reverses the sweep direction part way through a sweep. The number of LEDs and the width of the lit group are parameters. The pattern lives in a shift register. A two-state direction machine, with the states `DIR_UP` and `DIR_DOWN`, decides which way each step goes.

The direction machine has these transitions:
- `FLIP_IDLE`: a flip pulse with no tick swaps `DIR_UP` and `DIR_DOWN`.
- `WALL_HIGH`: a tick while the group touches the most significant end forces `DIR_DOWN`.
- `WALL_LOW`: a tick while the group touches the least significant end forces `DIR_UP`.
- `FLIP_STEP`: a tick away from both ends, together with a flip, swaps the direction and steps the new way.
- `HOLD`: in every other case the state is kept.

Top module: `led_chase_seq`

## Requirements
- R1: During and right after reset, `led_out` has its `GROUP_W` least significant bits set and all other bits clear, and the direction is toward the most significant end.
- R2: On each cycle where `step_tick` is 1, the lit group moves exactly one bit position in the current direction. Toward the most significant end is a left shift.
- R3: On a cycle where `step_tick` is 0, `led_out` keeps its value, even when `dir_flip` is 1.
- R4: A `dir_flip` pulse with no tick inverts the direction. The next tick then moves the group the new way.
- R5: A tick while bit `NUM_LEDS-1` is lit moves the group one position down and leaves the direction down. A tick while bit 0 is lit moves the group one position up and leaves the direction up.
- R6: When `dir_flip` and `step_tick` are both 1 while the group touches an end, the flip is ignored and only the automatic reversal applies.
- R7: When `dir_flip` and `step_tick` are both 1 while the group touches neither end, the step in that cycle goes in the inverted direction.
- R8: Exactly `GROUP_W` adjacent LEDs are lit at every cycle, and the group never shifts past either end.
- R9: With `GROUP_W` = 2, two adjacent LEDs are lit, and the same sweep and reversal rules apply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_tick | input | 1 | One-cycle step enable from the rate divider |
| dir_flip | input | 1 | One-cycle debounced request to reverse the direction |
| led_out | output | NUM_LEDS | LED drive, with one bit per LED |

## Verification
Some rules are checked by the embedded assertions on every cycle:
- the lit count always equals the group width;
- the pattern holds on cycles with no tick;
- a step is never requested toward an end that is already lit;
- the direction state is forced at each wall;
- an idle flip always changes the state.

Other behaviour can only be shown by the bench's scenarios. This covers the exact position after each step, the delayed effect of an idle flip on the following tick, the dropped flip at a wall, and the two-wide group on a longer row. The bench compares each of these against an independent model of position and direction.

// File: rtl/chase_pkg.sv
package chase_pkg;
    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } chase_dir_e;
endpackage

// File: rtl/chase_dir_fsm.sv
module chase_dir_fsm
    import chase_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic step_tick,
    input  logic dir_flip,
    input  logic at_low,
    input  logic at_high,
    output logic step_en,
    output logic step_up
);
    chase_dir_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= DIR_UP;
        else        state_q <= state_d;
    end

    // next state and the step direction
    always_comb begin
        state_d = state_q;
        if (step_tick) begin
            if (at_high)       state_d = DIR_DOWN;   // WALL_HIGH
            else if (at_low)   state_d = DIR_UP;     // WALL_LOW
            else if (dir_flip) begin                 // FLIP_STEP
                unique case (state_q)
                    DIR_UP:   state_d = DIR_DOWN;
                    DIR_DOWN: state_d = DIR_UP;
                endcase
            end
        end else if (dir_flip) begin                 // FLIP_IDLE
            unique case (state_q)
                DIR_UP:   state_d = DIR_DOWN;
                DIR_DOWN: state_d = DIR_UP;
            endcase
        end
    end

    // outputs to the shifter
    always_comb begin
        step_en = step_tick;
        step_up = (state_d == DIR_UP);
    end

    assert_wall_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        step_tick && at_high |=> state_q == DIR_DOWN);
    assert_wall_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        step_tick && at_low |=> state_q == DIR_UP);
    assert_flip_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !step_tick && dir_flip |=> state_q != $past(state_q));
    assert_wall_flip_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        step_tick && dir_flip && at_low |=> state_q == DIR_UP);
endmodule

// File: rtl/chase_shifter.sv
module chase_shifter #(
    parameter int NUM_LEDS = 4,
    parameter int GROUP_W  = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                step_en,
    input  logic                step_up,
    output logic [NUM_LEDS-1:0] pattern,
    output logic                at_low,
    output logic                at_high
);
    localparam int IDLE_W = NUM_LEDS - GROUP_W;
    localparam logic [NUM_LEDS-1:0] INIT_PAT = {{IDLE_W{1'b0}}, {GROUP_W{1'b1}}};

    logic [NUM_LEDS-1:0] pat_q, pat_d;

    for (genvar i = 0; i < NUM_LEDS; i++) begin : g_bit
        logic from_below, from_above;
        if (i == 0) begin : g_lsb
            assign from_below = 1'b0;
        end else begin : g_mid_lo
            assign from_below = pat_q[i-1];
        end
        if (i == NUM_LEDS-1) begin : g_msb
            assign from_above = 1'b0;
        end else begin : g_mid_hi
            assign from_above = pat_q[i+1];
        end
        assign pat_d[i] = !step_en ? pat_q[i] : (step_up ? from_below : from_above);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pat_q <= INIT_PAT;
        else        pat_q <= pat_d;
    end

    always_comb begin
        pattern = pat_q;
        at_low  = pat_q[0];
        at_high = pat_q[NUM_LEDS-1];
    end

    initial begin
        assert_legal_size_R8: assert (NUM_LEDS > GROUP_W && GROUP_W >= 1);
    end

    assert_group_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(pat_q) == GROUP_W);
    assert_no_push_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        step_en && step_up |-> !pat_q[NUM_LEDS-1]);
    assert_no_push_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        step_en && !step_up |-> !pat_q[0]);
    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en |=> $stable(pat_q));
endmodule

// File: rtl/led_chase_seq.sv
module led_chase_seq #(
    parameter int NUM_LEDS = 4,
    parameter int GROUP_W  = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                step_tick,
    input  logic                dir_flip,
    output logic [NUM_LEDS-1:0] led_out
);
    logic step_en, step_up, at_low, at_high;

    chase_dir_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_tick(step_tick),
        .dir_flip (dir_flip),
        .at_low   (at_low),
        .at_high  (at_high),
        .step_en  (step_en),
        .step_up  (step_up)
    );

    chase_shifter #(.NUM_LEDS(NUM_LEDS), .GROUP_W(GROUP_W)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_en(step_en),
        .step_up(step_up),
        .pattern(led_out),
        .at_low (at_low),
        .at_high(at_high)
    );
endmodule

// File: tb/tb_led_chase_seq.sv
`timescale 1ns/1ps
module tb_led_chase_seq;
    localparam int N1 = 4, G1 = 1;
    localparam int N2 = 6, G2 = 2;

    logic clk = 0;
    logic rst_n = 0;
    logic tick = 0, flip = 0;
    logic [N1-1:0] led1;
    logic [N2-1:0] led2;

    always #2.5 clk = ~clk;

    led_chase_seq #(.NUM_LEDS(N1), .GROUP_W(G1)) dut (
        .clk(clk), .rst_n(rst_n), .step_tick(tick), .dir_flip(flip), .led_out(led1));
    led_chase_seq #(.NUM_LEDS(N2), .GROUP_W(G2)) dut2 (
        .clk(clk), .rst_n(rst_n), .step_tick(tick), .dir_flip(flip), .led_out(led2));

    typedef struct {
        logic [N1-1:0] e1;
        logic [N2-1:0] e2;
        string         tag;
    } exp_t;
    exp_t sb[$];

    int total = 0, bad = 0;
    int pos1, pos2;
    bit up1, up2;

    function automatic void model_step(ref int pos, ref bit up, input int maxpos,
                                       input bit t, input bit f);
        if (t) begin
            if (pos == maxpos)  up = 0;
            else if (pos == 0)  up = 1;
            else                up = up ^ f;
            pos = up ? pos + 1 : pos - 1;
        end else begin
            up = up ^ f;
        end
    endfunction

    task automatic drive(input bit t, input bit f, input string tag);
        exp_t e;
        @(negedge clk);
        tick = t; flip = f;
        model_step(pos1, up1, N1-G1, t, f);
        model_step(pos2, up2, N2-G2, t, f);
        e.e1 = N1'(((1 << G1) - 1) << pos1);
        e.e2 = N2'(((1 << G2) - 1) << pos2);
        e.tag = tag;
        sb.push_back(e);
    endtask

    // monitor: compare after each edge
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            total++;
            if (led1 !== e.e1) begin
                bad++;
                $display("FAIL %s dut: got %b exp %b", e.tag, led1, e.e1);
            end
            total++;
            if (led2 !== e.e2) begin
                bad++;
                $display("FAIL %s dut2: got %b exp %b", e.tag, led2, e.e2);
            end
        end
    end

    initial begin
        fork
            begin
                pos1 = 0; pos2 = 0; up1 = 1; up2 = 1;
                repeat (3) @(negedge clk);
                total++;
                if (led1 !== 4'b0001) begin
                    bad++; $display("FAIL R1 dut: got %b exp %b", led1, 4'b0001);
                end
                total++;
                if (led2 !== 6'b000011) begin
                    bad++; $display("FAIL R1 dut2: got %b exp %b", led2, 6'b000011);
                end
                rst_n = 1;
                // R1/R2: first ticks go up
                drive(1, 0, "R2");
                drive(1, 0, "R2");
                // R3: no tick holds, even with a flip in between
                drive(0, 0, "R3");
                drive(0, 1, "R3");
                drive(0, 1, "R3");
                // R5: sweep into the top wall and back
                repeat (5) drive(1, 0, "R5");
                // R5 bottom wall
                repeat (6) drive(1, 0, "R5");
                // R4: idle flip, then the next tick goes the new way
                drive(1, 0, "R2");
                drive(0, 1, "R4");
                drive(1, 0, "R4");
                drive(1, 0, "R5");
                // R6: flip together with a tick at the low wall
                drive(1, 1, "R6");
                repeat (2) drive(1, 0, "R9");
                // R6: flip together with a tick at the high wall
                drive(1, 1, "R6");
                // R7: flip together with a tick mid-row
                drive(1, 1, "R7");
                drive(1, 1, "R7");
                drive(1, 0, "R7");
                // R8/R9: long mixed run
                for (int k = 0; k < 40; k++) drive(((k % 3) != 2), (k % 5) == 0, "R8");
                drive(0, 0, "R9");
                @(negedge clk);
                @(negedge clk);
            end
            begin
                repeat (5000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog: got timeout exp finish");
            end
        join_any
        disable fork;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule